// File: doc/BRIEF.md
# Masked Data-Access and Register Break Comparator

This block watches a processor core while it runs under emulation and raises a break request when one of two programmed conditions is met. The first condition looks at data-memory bus cycles. It matches on an inclusive address window, on a data nibble that can be masked bit by bit, and on the transfer direction, which can also be masked. The second condition looks at the register snapshot the core presents when each instruction retires. It covers the A and B nibbles, the four-bit flag field (E, I, C, Z), and the 16-bit X and Y registers, and each part can be excluded on its own.

A register match cannot halt the core while an interrupt acknowledge is in progress. In that case the match is parked in a pending flag. The break is issued on the first retired instruction after the acknowledge ends, which is the first instruction of the handler after the vector jump. The surrounding break controller confirms that it has taken a break with an acknowledge input, and this input discards a parked match. Both comparators are active only while the emulation-active input is high.

Top module: `dbgbrk_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, brk_data, brk_reg, brk_pend and brk_req are all 0.
- R2: A data access matches when bus_stb is high, the address is within cfg_lo..cfg_hi with both ends included, every data bit whose cfg_dmask bit is 1 equals cfg_dval, and the direction condition holds. On a match, brk_data is 1 for exactly the one cycle after the strobe's clock edge.
- R3: Addresses one below cfg_lo and one above cfg_hi never match. Both window ends do match.
- R4: Data bits whose cfg_dmask bit is 0 do not affect the match.
- R5: bus_wr=1 marks a write and bus_wr=0 marks a read. A dummy read made by a software-interrupt instruction is a read. With cfg_dir_care=1 the access matches only when bus_wr equals cfg_dir_wr. With cfg_dir_care=0 either direction matches.
- R6: When instr_done is high and iack_n is high, the register condition is evaluated. If every enabled part is equal, brk_reg is 1 for exactly the next cycle.
- R7: rcfg_care disables whole registers: bit0 is A, bit1 is B, bit2 is X, bit3 is Y, and a 0 bit means the register is ignored. rcfg_flag_mask selects individual flags: bit3 is E, bit2 is I, bit1 is C, bit0 is Z, and a 0 bit means the flag is ignored. With everything disabled, every retired instruction matches.
- R8: A register match while iack_n is low does not raise brk_reg. Instead, brk_pend is 1 from the next cycle on.
- R9: While brk_pend is 1, the first instr_done with iack_n high and emu_run high raises brk_reg for one cycle, whatever the snapshot holds, and clears brk_pend in the same cycle.
- R10: brk_ack clears brk_pend in the next cycle. It wins over a capture in the same cycle.
- R11: While emu_run is low, no data match, register match, capture or release takes place.
- R12: brk_req equals brk_data OR brk_reg in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_run | input | 1 | Emulation active; enables both comparators |
| bus_addr | input | 16 | Data-memory address of the current access |
| bus_data | input | 4 | Data nibble of the current access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_stb | input | 1 | Access-complete strobe |
| cfg_lo | input | 16 | Lower window bound (inclusive) |
| cfg_hi | input | 16 | Upper window bound (inclusive) |
| cfg_dval | input | 4 | Data value to compare |
| cfg_dmask | input | 4 | Per-bit compare enable for data |
| cfg_dir_wr | input | 1 | Direction to match |
| cfg_dir_care | input | 1 | Direction compare enable |
| snap_a | input | 4 | Retired A register |
| snap_b | input | 4 | Retired B register |
| snap_flags | input | 4 | Retired flags {E,I,C,Z} |
| snap_x | input | 16 | Retired X register |
| snap_y | input | 16 | Retired Y register |
| instr_done | input | 1 | Instruction-retire strobe |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| rcfg_a | input | 4 | A value to compare |
| rcfg_b | input | 4 | B value to compare |
| rcfg_flags | input | 4 | Flag values to compare |
| rcfg_x | input | 16 | X value to compare |
| rcfg_y | input | 16 | Y value to compare |
| rcfg_care | input | 4 | Register enables {Y,X,B,A} |
| rcfg_flag_mask | input | 4 | Per-flag compare enable |
| brk_ack | input | 1 | Break taken; discards a parked register match |
| brk_data | output | 1 | Data-access break pulse |
| brk_reg | output | 1 | Register break pulse |
| brk_pend | output | 1 | Register match parked during acknowledge |
| brk_req | output | 1 | Combined break request |

## Verification
The assertions assume that the configuration inputs hold steady over an access and its result cycle, and that reset is held for at least one clock edge, so that every $past sample was taken after reset. The stimulus changes the configuration only between directed phases. It drives every input right after the falling edge, so each rising edge sees one consistent set of inputs. In the random phase the addresses cluster around the window ends, and the interrupt acknowledge, the retire strobe and the break acknowledge are toggled freely, so that captures, releases and acknowledge collisions all occur.

// File: rtl/dbgbrk_pkg.sv
package dbgbrk_pkg;
   localparam int IDX_A     = 0;
   localparam int IDX_B     = 1;
   localparam int IDX_X     = 2;
   localparam int IDX_Y     = 3;
   localparam int NUM_CARE  = 4;
endpackage

// File: rtl/dbgbrk_field_eq.sv
module dbgbrk_field_eq #(
   parameter int W = 4
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  logic [W-1:0] sel,
   output logic         eq
);
   if (W < 1) begin : g_bad_w
      $error("dbgbrk_field_eq: W must be positive");
   end

   logic [W-1:0] diff;
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign diff[i] = sel[i] & (lhs[i] ^ rhs[i]);
   end
   assign eq = ~|diff;
endmodule

// File: rtl/dbgbrk_data_cmp.sv
module dbgbrk_data_cmp #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 4,
   parameter bit HI_INCL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              wr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [DATA_W-1:0] dval,
   input  logic [DATA_W-1:0] dmask,
   input  logic              dir_wr,
   input  logic              dir_care,
   output logic              hit
);
   logic in_rng, data_eq, dir_ok;

   if (HI_INCL) begin : g_incl
      assign in_rng = (addr >= lo) && (addr <= hi);
   end else begin : g_excl
      assign in_rng = (addr >= lo) && (addr < hi);
   end

   dbgbrk_field_eq #(.W(DATA_W)) u_deq (
      .lhs(data), .rhs(dval), .sel(dmask), .eq(data_eq)
   );

   assign dir_ok = ~dir_care | (wr == dir_wr);
   assign hit    = in_rng & data_eq & dir_ok;
endmodule

// File: rtl/dbgbrk_reg_cmp.sv
module dbgbrk_reg_cmp
   import dbgbrk_pkg::*;
#(
   parameter int NIB_W  = 4,
   parameter int FLAG_W = 4,
   parameter int IDX_W  = 16
) (
   input  logic [NIB_W-1:0]    s_a,
   input  logic [NIB_W-1:0]    s_b,
   input  logic [FLAG_W-1:0]   s_f,
   input  logic [IDX_W-1:0]    s_x,
   input  logic [IDX_W-1:0]    s_y,
   input  logic [NIB_W-1:0]    c_a,
   input  logic [NIB_W-1:0]    c_b,
   input  logic [FLAG_W-1:0]   c_f,
   input  logic [IDX_W-1:0]    c_x,
   input  logic [IDX_W-1:0]    c_y,
   input  logic [NUM_CARE-1:0] care,
   input  logic [FLAG_W-1:0]   fmask,
   output logic                match
);
   logic eq_a, eq_b, eq_f, eq_x, eq_y;

   dbgbrk_field_eq #(.W(NIB_W)) u_a (
      .lhs(s_a), .rhs(c_a), .sel({NIB_W{care[IDX_A]}}), .eq(eq_a));
   dbgbrk_field_eq #(.W(NIB_W)) u_b (
      .lhs(s_b), .rhs(c_b), .sel({NIB_W{care[IDX_B]}}), .eq(eq_b));
   dbgbrk_field_eq #(.W(FLAG_W)) u_f (
      .lhs(s_f), .rhs(c_f), .sel(fmask), .eq(eq_f));
   dbgbrk_field_eq #(.W(IDX_W)) u_x (
      .lhs(s_x), .rhs(c_x), .sel({IDX_W{care[IDX_X]}}), .eq(eq_x));
   dbgbrk_field_eq #(.W(IDX_W)) u_y (
      .lhs(s_y), .rhs(c_y), .sel({IDX_W{care[IDX_Y]}}), .eq(eq_y));

   assign match = eq_a & eq_b & eq_f & eq_x & eq_y;
endmodule

// File: rtl/dbgbrk_top.sv
module dbgbrk_top
   import dbgbrk_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 4,
   parameter int NIB_W  = 4,
   parameter int FLAG_W = 4,
   parameter int IDX_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                emu_run,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_data,
   input  logic                bus_wr,
   input  logic                bus_stb,
   input  logic [ADDR_W-1:0]   cfg_lo,
   input  logic [ADDR_W-1:0]   cfg_hi,
   input  logic [DATA_W-1:0]   cfg_dval,
   input  logic [DATA_W-1:0]   cfg_dmask,
   input  logic                cfg_dir_wr,
   input  logic                cfg_dir_care,
   input  logic [NIB_W-1:0]    snap_a,
   input  logic [NIB_W-1:0]    snap_b,
   input  logic [FLAG_W-1:0]   snap_flags,
   input  logic [IDX_W-1:0]    snap_x,
   input  logic [IDX_W-1:0]    snap_y,
   input  logic                instr_done,
   input  logic                iack_n,
   input  logic [NIB_W-1:0]    rcfg_a,
   input  logic [NIB_W-1:0]    rcfg_b,
   input  logic [FLAG_W-1:0]   rcfg_flags,
   input  logic [IDX_W-1:0]    rcfg_x,
   input  logic [IDX_W-1:0]    rcfg_y,
   input  logic [NUM_CARE-1:0] rcfg_care,
   input  logic [FLAG_W-1:0]   rcfg_flag_mask,
   input  logic                brk_ack,
   output logic                brk_data,
   output logic                brk_reg,
   output logic                brk_pend,
   output logic                brk_req
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("dbgbrk_top: bus widths must be positive");
   end
   if (NIB_W < 1 || FLAG_W < 1 || IDX_W < 1) begin : g_bad_reg
      $error("dbgbrk_top: register widths must be positive");
   end

   logic d_hit, r_match;
   logic d_fire, r_eval, r_cap, r_rel;

   dbgbrk_data_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_INCL(1'b1)) u_dcmp (
      .addr(bus_addr), .data(bus_data), .wr(bus_wr),
      .lo(cfg_lo), .hi(cfg_hi), .dval(cfg_dval), .dmask(cfg_dmask),
      .dir_wr(cfg_dir_wr), .dir_care(cfg_dir_care), .hit(d_hit)
   );

   dbgbrk_reg_cmp #(.NIB_W(NIB_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)) u_rcmp (
      .s_a(snap_a), .s_b(snap_b), .s_f(snap_flags), .s_x(snap_x), .s_y(snap_y),
      .c_a(rcfg_a), .c_b(rcfg_b), .c_f(rcfg_flags), .c_x(rcfg_x), .c_y(rcfg_y),
      .care(rcfg_care), .fmask(rcfg_flag_mask), .match(r_match)
   );

   assign d_fire = emu_run & bus_stb & d_hit;
   assign r_eval = emu_run & instr_done;
   assign r_cap  = r_eval & ~iack_n & r_match;
   assign r_rel  = r_eval & iack_n & brk_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk_data <= 1'b0;
         brk_reg  <= 1'b0;
         brk_pend <= 1'b0;
      end else begin
         brk_data <= d_fire;
         brk_reg  <= r_eval & iack_n & (r_match | brk_pend);
         if (brk_ack || r_rel)
            brk_pend <= 1'b0;
         else if (r_cap)
            brk_pend <= 1'b1;
      end
   end

   assign brk_req = brk_data | brk_reg;
endmodule

// File: rtl/dbgbrk_chk.sv
module dbgbrk_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              emu_run,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_stb,
   input logic [ADDR_W-1:0] cfg_lo,
   input logic [ADDR_W-1:0] cfg_hi,
   input logic              instr_done,
   input logic              iack_n,
   input logic              brk_ack,
   input logic              brk_data,
   input logic              brk_reg,
   input logic              brk_pend
);
   // R2
   data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_data |-> $past(bus_stb && emu_run));

   // R3
   data_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_data |-> $past(bus_addr >= cfg_lo && bus_addr <= cfg_hi));

   // R6
   reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_reg |-> $past(instr_done && iack_n && emu_run));

   // R8
   iack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && !iack_n) |=> !brk_reg);

   // R10
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ack |=> !brk_pend);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !emu_run |=> (!brk_data && !brk_reg));
endmodule

bind dbgbrk_top dbgbrk_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .emu_run(emu_run), .bus_addr(bus_addr),
   .bus_stb(bus_stb), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
   .instr_done(instr_done), .iack_n(iack_n), .brk_ack(brk_ack),
   .brk_data(brk_data), .brk_reg(brk_reg), .brk_pend(brk_pend)
);

// File: tb/dbgbrk_top_bench.sv
module dbgbrk_top_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n, emu_run, bus_wr, bus_stb, cfg_dir_wr, cfg_dir_care;
   logic instr_done, iack_n, brk_ack;
   logic [15:0] bus_addr, cfg_lo, cfg_hi, snap_x, snap_y, rcfg_x, rcfg_y;
   logic [3:0]  bus_data, cfg_dval, cfg_dmask, snap_a, snap_b, snap_flags;
   logic [3:0]  rcfg_a, rcfg_b, rcfg_flags, rcfg_care, rcfg_flag_mask;
   logic brk_data, brk_reg, brk_pend, brk_req;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;
   bit m_pend = 0;
   logic [3:0] exp_v = 4'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbgbrk_top u_dbgbrk_top (.*);

   task automatic predict();
      bit dh, rm, rel, cap, nd, nr, np;
      dh = emu_run && bus_stb && bus_addr >= cfg_lo && bus_addr <= cfg_hi &&
           ((bus_data ^ cfg_dval) & cfg_dmask) == 4'd0 &&
           (!cfg_dir_care || bus_wr == cfg_dir_wr);
      rm = (!rcfg_care[0] || snap_a == rcfg_a) && (!rcfg_care[1] || snap_b == rcfg_b) &&
           (!rcfg_care[2] || snap_x == rcfg_x) && (!rcfg_care[3] || snap_y == rcfg_y) &&
           ((snap_flags ^ rcfg_flags) & rcfg_flag_mask) == 4'd0;
      rel = emu_run && instr_done && iack_n && m_pend;
      cap = emu_run && instr_done && !iack_n && rm;
      nd  = dh;
      nr  = emu_run && instr_done && iack_n && (rm || m_pend);
      if (brk_ack || rel) np = 0;
      else if (cap)       np = 1;
      else                np = m_pend;
      if (!rst_n) begin nd = 0; nr = 0; np = 0; end
      m_pend = np;
      exp_v  = {nd, nr, np, nd | nr};
   endtask

   // one clock: predict from the inputs now applied, then compare after the edge
   task automatic cyc(string tag);
      logic [3:0] act;
      predict();
      @(negedge clk);
      act = {brk_data, brk_reg, brk_pend, brk_req};
      compared++;
      if (act !== exp_v) begin
         mismatched++;
         $display("FAIL %s: {data,reg,pend,req} actual=%b expected=%b", tag, act, exp_v);
      end
   endtask

   task automatic quiet();
      bus_stb = 0; instr_done = 0; brk_ack = 0; iack_n = 1;
   endtask

   task automatic access(logic [15:0] a, logic [3:0] d, logic w, string tag);
      bus_addr = a; bus_data = d; bus_wr = w; bus_stb = 1;
      cyc(tag);
      bus_stb = 0;
      cyc(tag);
   endtask

   task automatic retire(logic ia, string tag);
      instr_done = 1; iack_n = ia;
      cyc(tag);
      instr_done = 0; iack_n = 1;
      cyc(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      rst_n = 0; emu_run = 1; quiet();
      bus_addr = 0; bus_data = 0; bus_wr = 0;
      cfg_lo = 16'h1000; cfg_hi = 16'h10FF; cfg_dval = 4'hA; cfg_dmask = 4'hF;
      cfg_dir_wr = 1; cfg_dir_care = 1;
      snap_a = 4'h3; snap_b = 4'h5; snap_flags = 4'b0100; snap_x = 16'h1234; snap_y = 16'hBEEF;
      rcfg_a = 4'h3; rcfg_b = 4'h5; rcfg_flags = 4'b0100; rcfg_x = 16'h1234; rcfg_y = 16'hBEEF;
      rcfg_care = 4'hF; rcfg_flag_mask = 4'hF;
      // R1 reset state
      bus_stb = 1; bus_addr = 16'h1000; bus_data = 4'hA; bus_wr = 1; instr_done = 1;
      repeat (3) cyc("R1");
      quiet(); rst_n = 1;
      cyc("R1");
      // R2 basic write hit
      access(16'h1040, 4'hA, 1, "R2");
      access(16'h1040, 4'hB, 1, "R2");
      // R3 window edges
      access(16'h0FFF, 4'hA, 1, "R3");
      access(16'h1100, 4'hA, 1, "R3");
      access(16'h1000, 4'hA, 1, "R3");
      access(16'h10FF, 4'hA, 1, "R3");
      // R4 data mask
      cfg_dmask = 4'b1100;
      access(16'h1001, 4'hB, 1, "R4");
      access(16'h1001, 4'h6, 1, "R4");
      cfg_dmask = 4'h0;
      access(16'h1001, 4'h0, 1, "R4");
      // R5 direction, dummy read of a software interrupt is a read
      access(16'h1002, 4'h1, 0, "R5");
      cfg_dir_care = 0;
      access(16'h1002, 4'h1, 0, "R5");
      cfg_dir_care = 1; cfg_dir_wr = 0;
      access(16'h1002, 4'h1, 0, "R5");
      access(16'h1002, 4'h1, 1, "R5");
      // R6 register match
      retire(1, "R6");
      snap_x = 16'h1235;
      retire(1, "R6");
      // R7 masks
      rcfg_care = 4'b1011;
      retire(1, "R7");
      snap_flags = 4'b0101;
      retire(1, "R7");
      rcfg_flag_mask = 4'b1110;
      retire(1, "R7");
      rcfg_care = 4'h0; rcfg_flag_mask = 4'h0; snap_a = 4'hF;
      retire(1, "R7");
      rcfg_care = 4'hF; rcfg_flag_mask = 4'hF;
      snap_a = 4'h3; snap_x = 16'h1234; snap_flags = 4'b0100;
      // R8 capture during acknowledge
      retire(0, "R8");
      cyc("R8");
      // R9 release on non-matching retire
      snap_y = 16'h0000;
      retire(1, "R9");
      snap_y = 16'hBEEF;
      // R10 acknowledge clears and wins over capture
      retire(0, "R10");
      brk_ack = 1; cyc("R10"); brk_ack = 0;
      retire(1, "R10");
      instr_done = 1; iack_n = 0; brk_ack = 1;
      cyc("R10");
      quiet(); cyc("R10");
      // R11 emulation inactive
      emu_run = 0;
      access(16'h1010, 4'h1, 0, "R11");
      retire(1, "R11");
      retire(0, "R11");
      emu_run = 1;
      retire(0, "R11");
      emu_run = 0;
      retire(1, "R11");
      emu_run = 1;
      retire(1, "R11");
      // R12 random traffic, combined request checked each cycle
      cfg_dmask = 4'b1010; cfg_dir_care = 1; cfg_dir_wr = 1;
      rcfg_care = 4'b0011; rcfg_flag_mask = 4'b0010;
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         bus_stb = r[0]; bus_wr = r[1]; bus_data = r[5:2];
         bus_addr = r[6] ? (16'h0FFE + 16'(r[9:7])) : (16'h10FC + 16'(r[9:7]));
         instr_done = r[10]; iack_n = r[11] | r[12];
         brk_ack = (r[15:13] == 3'd0);
         emu_run = (r[18:16] != 3'd0);
         snap_a = r[19] ? 4'h3 : 4'h2; snap_b = r[20] ? 4'h5 : 4'h4;
         snap_flags = r[24:21];
         cyc("R12");
      end
      quiet(); emu_run = 1;
      cyc("R12");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule